// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command front end of a byte-wide, single-supply flash device holding 128K bytes. It watches write cycles on a simple bus and recognises the two-cycle unlock prefix. It then dispatches byte program, identification (autoselect) mode, sector or whole-array erase, and erase suspend and resume. Any unexpected cycle sends it back to plain array reads. A down-counter stands in for the duration of the embedded program and erase operations. While one of these runs, the controller ignores command writes and returns a polling status byte on the read path.

The storage array sits outside the block. The block drives the array read address. At the end of a program it issues a one-cycle write strobe that carries the merged byte. At the end of an erase it issues a one-cycle erase strobe with a mask of the sectors to wipe. Sector protection comes in as one bit per sector and is honoured by both program and erase. In identification mode the read path returns fixed identity codes and per-sector protection flags instead of array data.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode: `busy`, `ident_mode` and `suspended` are low and `rd_data` equals `arr_rdata` for `arr_addr` = `rd_addr`.
- R2: Only AAh at low address 555h can open a sequence, and only 55h at 2AAh can follow it. A write with the wrong low address (bits 10:0) or the wrong data returns the block to array-read mode, and a command byte that follows is not acted on.
- R3: AAh@555h, 55h@2AAh, A0h@555h and then data D at address A raise `busy` on the edge that takes the fourth write. `busy` stays high for exactly PGM_CYC cycles, and `pgm_stb` pulses in the last of them with `pgm_addr` = A. The block then reads the array again.
- R4: The byte written by a program is the bitwise AND of the old array byte and D, so a program can only clear bits.
- R5: While a program runs, every write is ignored, F0h included, and `rd_data` is {~D[7], 7'b0}.
- R6: F0h written between unlock cycles at any address returns the block to array-read mode before any operation starts.
- R7: AAh@555h, 55h@2AAh, 90h@555h enter identification mode. With read low byte 00h, 01h or 03h, `rd_data` is MFR_ID, DEV_ID or CONT_ID. Any other low byte except 02h returns 00h.
- R8: In identification mode a read whose low byte is 02h returns 01h if the sector selected by address bits [ADDR_W-1 -: SECT_W] is protected, and 00h if it is not.
- R9: Identification mode lasts for any number of reads and writes. Only a write with data F0h, at any address, ends it.
- R10: A program aimed at a protected sector ends at once: `busy` never rises, and the array byte is unchanged.
- R11: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h and 55h@2AAh, followed by either 30h at a sector address or 10h@555h, start an erase that is busy for ERS_CYC cycles. `rd_data` reads 00h while it runs. `ers_stb` then pulses with `ers_mask` set to that sector's one-hot bit, or to every unprotected sector for 10h. An erase that would touch no unprotected sector ends at once.
- R12: B0h written during an erase suspends it: `busy` falls, `suspended` rises and the array reads normally. The remaining time is frozen and other writes are ignored. 30h resumes the erase for exactly the time that was left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One write cycle per high clock |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data |
| rd_addr | input | ADDR_W | Read address from the host |
| rd_data | output | 8 | Read data: array, identity code or status |
| arr_addr | output | ADDR_W | Array read address |
| arr_rdata | input | 8 | Array byte at `arr_addr` (combinational) |
| sect_prot | input | 2**SECT_W | Protection flag per sector |
| pgm_stb | output | 1 | Array byte write strobe |
| pgm_addr | output | ADDR_W | Address of the byte to write |
| pgm_wdata | output | 8 | Merged byte to write |
| ers_stb | output | 1 | Array erase strobe |
| ers_mask | output | 2**SECT_W | Sectors to erase |
| busy | output | 1 | Embedded operation running |
| ident_mode | output | 1 | Identification mode active |
| suspended | output | 1 | Erase suspended |

## Verification
The bench builds the block with ADDR_W=17 and SECT_W=3, which gives the full 128K map in eight 16K sectors, with sectors 2 and 5 protected. PGM_CYC=6 and ERS_CYC=20 are short enough that program completion, a suspend in the middle of an erase, a long suspended wait and the exact remaining time after resume all fall within a few hundred cycles. The bench compares every output against a behavioural model on every cycle. It also makes directed reads whose expected bytes are worked out by hand.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PSET,
    ST_EUN0, ST_EUN1, ST_EUN2, ST_IDENT,
    ST_PBUSY, ST_EBUSY, ST_ESUSP
  } fc_state_e;

  localparam logic [10:0] ADR_KEY_A = 11'h555;
  localparam logic [10:0] ADR_KEY_B = 11'h2AA;

  localparam logic [7:0] CD_KEY_A   = 8'hAA;
  localparam logic [7:0] CD_KEY_B   = 8'h55;
  localparam logic [7:0] CD_PROG    = 8'hA0;
  localparam logic [7:0] CD_IDENT   = 8'h90;
  localparam logic [7:0] CD_ERASE   = 8'h80;
  localparam logic [7:0] CD_SECT    = 8'h30;
  localparam logic [7:0] CD_CHIP    = 8'h10;
  localparam logic [7:0] CD_RESET   = 8'hF0;
  localparam logic [7:0] CD_SUSP    = 8'hB0;
  localparam logic [7:0] CD_RESUME  = 8'h30;

  function automatic logic cyc_match(input logic [10:0] a, input logic [7:0] d,
                                     input logic [10:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  // a program can only move bits from 1 to 0
  function automatic logic [7:0] merge_prog(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] poll_byte(input logic in_prog, input logic data7);
    return {in_prog ? ~data7 : 1'b0, 7'b0};
  endfunction

endpackage

// File: rtl/flash_op_timer.sv
`timescale 1ns/1ps
module flash_op_timer #(
  parameter int PGM_CYC = 16,
  parameter int ERS_CYC = 64,
  localparam int MAXC  = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC,
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_pgm,
  input  logic             load_ers,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (load_pgm)           cnt <= CNT_W'(PGM_CYC - 1);
    else if (load_ers)           cnt <= CNT_W'(ERS_CYC - 1);
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/flash_seq_fsm.sv
`timescale 1ns/1ps
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int SECT_W = 3,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [NSECT-1:0]  sect_prot,
  input  logic              tmr_done,
  output fc_state_e         st,
  output logic [ADDR_W-1:0] pa,
  output logic [7:0]        pd,
  output logic [NSECT-1:0]  emask,
  output logic              pgm_go,
  output logic              pgm_refuse,
  output logic              ers_go,
  output logic              susp_ev,
  output logic              res_ev
);
  fc_state_e          nxt;
  logic [10:0]        lo;
  logic [SECT_W-1:0]  wsec;
  logic [NSECT-1:0]   cand;
  logic [NSECT-1:0]   masked;
  logic               is_ers;

  assign lo   = wr_addr[10:0];
  assign wsec = wr_addr[ADDR_W-1 -: SECT_W];

  always_comb begin
    is_ers = 1'b0;
    cand   = '0;
    if (wr_data == CD_SECT) begin
      is_ers = 1'b1;
      cand   = NSECT'(1) << wsec;
    end else if (cyc_match(lo, wr_data, ADR_KEY_A, CD_CHIP)) begin
      is_ers = 1'b1;
      cand   = '1;
    end
    masked = cand & ~sect_prot;
  end

  always_comb begin
    nxt        = st;
    pgm_go     = 1'b0;
    pgm_refuse = 1'b0;
    ers_go     = 1'b0;
    susp_ev    = 1'b0;
    res_ev     = 1'b0;
    unique case (st)
      ST_READ:  if (wr_en && cyc_match(lo, wr_data, ADR_KEY_A, CD_KEY_A)) nxt = ST_UNL1;
      ST_UNL1:  if (wr_en) nxt = cyc_match(lo, wr_data, ADR_KEY_B, CD_KEY_B) ? ST_UNL2 : ST_READ;
      ST_UNL2:  if (wr_en) begin
                  if      (cyc_match(lo, wr_data, ADR_KEY_A, CD_PROG))  nxt = ST_PSET;
                  else if (cyc_match(lo, wr_data, ADR_KEY_A, CD_IDENT)) nxt = ST_IDENT;
                  else if (cyc_match(lo, wr_data, ADR_KEY_A, CD_ERASE)) nxt = ST_EUN0;
                  else                                                  nxt = ST_READ;
                end
      ST_PSET:  if (wr_en) begin
                  if (sect_prot[wsec]) begin pgm_refuse = 1'b1; nxt = ST_READ;  end
                  else                 begin pgm_go     = 1'b1; nxt = ST_PBUSY; end
                end
      ST_EUN0:  if (wr_en) nxt = cyc_match(lo, wr_data, ADR_KEY_A, CD_KEY_A) ? ST_EUN1 : ST_READ;
      ST_EUN1:  if (wr_en) nxt = cyc_match(lo, wr_data, ADR_KEY_B, CD_KEY_B) ? ST_EUN2 : ST_READ;
      ST_EUN2:  if (wr_en) begin
                  if (is_ers && masked != '0) begin ers_go = 1'b1; nxt = ST_EBUSY; end
                  else                                          nxt = ST_READ;
                end
      ST_IDENT: if (wr_en && wr_data == CD_RESET) nxt = ST_READ;
      ST_PBUSY: if (tmr_done) nxt = ST_READ;
      ST_EBUSY: begin
                  if (tmr_done) nxt = ST_READ;
                  else if (wr_en && wr_data == CD_SUSP) begin susp_ev = 1'b1; nxt = ST_ESUSP; end
                end
      ST_ESUSP: if (wr_en && wr_data == CD_RESUME) begin res_ev = 1'b1; nxt = ST_EBUSY; end
      default:  nxt = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_READ;
      pa    <= '0;
      pd    <= '0;
      emask <= '0;
    end else begin
      st <= nxt;
      if (pgm_go) begin
        pa <= wr_addr;
        pd <= wr_data;
      end
      if (ers_go) emask <= masked;
    end
  end
endmodule

// File: rtl/flash_rd_mux.sv
`timescale 1ns/1ps
module flash_rd_mux
  import flash_cmd_pkg::*;
#(
  parameter int          SECT_W  = 3,
  parameter logic [7:0]  MFR_ID  = 8'h37,
  parameter logic [7:0]  DEV_ID  = 8'hA1,
  parameter logic [7:0]  CONT_ID = 8'h7F,
  localparam int NSECT = 1 << SECT_W
) (
  input  fc_state_e         st,
  input  logic [7:0]        rd_lo,
  input  logic [SECT_W-1:0] rd_sec,
  input  logic [7:0]        arr_rdata,
  input  logic              pd7,
  input  logic [NSECT-1:0]  sect_prot,
  output logic [7:0]        rd_data
);
  logic [7:0] id_byte;

  always_comb begin
    unique case (rd_lo)
      8'h00:   id_byte = MFR_ID;
      8'h01:   id_byte = DEV_ID;
      8'h02:   id_byte = {7'b0, sect_prot[rd_sec]};
      8'h03:   id_byte = CONT_ID;
      default: id_byte = 8'h00;
    endcase
  end

  always_comb begin
    unique case (st)
      ST_IDENT: rd_data = id_byte;
      ST_PBUSY: rd_data = poll_byte(1'b1, pd7);
      ST_EBUSY: rd_data = poll_byte(1'b0, pd7);
      default:  rd_data = arr_rdata;
    endcase
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W  = 17,
  parameter int          SECT_W  = 3,
  parameter int          PGM_CYC = 16,
  parameter int          ERS_CYC = 64,
  parameter logic [7:0]  MFR_ID  = 8'h37,
  parameter logic [7:0]  DEV_ID  = 8'hA1,
  parameter logic [7:0]  CONT_ID = 8'h7F,
  localparam int NSECT = 1 << SECT_W,
  localparam int MAXC  = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC,
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [7:0]        arr_rdata,
  input  logic [NSECT-1:0]  sect_prot,
  output logic              pgm_stb,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [7:0]        pgm_wdata,
  output logic              ers_stb,
  output logic [NSECT-1:0]  ers_mask,
  output logic              busy,
  output logic              ident_mode,
  output logic              suspended
);
  fc_state_e        st;
  logic [7:0]       pd;
  logic             pgm_go, pgm_refuse, ers_go, susp_ev, res_ev;
  logic             tmr_done;
  logic [CNT_W-1:0] tmr_cnt;
  logic             prog_busy, ers_busy;

  flash_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sect_prot(sect_prot), .tmr_done(tmr_done), .st(st), .pa(pgm_addr), .pd(pd),
    .emask(ers_mask), .pgm_go(pgm_go), .pgm_refuse(pgm_refuse), .ers_go(ers_go),
    .susp_ev(susp_ev), .res_ev(res_ev)
  );

  assign prog_busy = (st == ST_PBUSY);
  assign ers_busy  = (st == ST_EBUSY);

  flash_op_timer #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load_pgm(pgm_go), .load_ers(ers_go),
    .run(prog_busy | ers_busy), .cnt(tmr_cnt), .done(tmr_done)
  );

  flash_rd_mux #(.SECT_W(SECT_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .CONT_ID(CONT_ID)) mux_i (
    .st(st), .rd_lo(rd_addr[7:0]), .rd_sec(rd_addr[ADDR_W-1 -: SECT_W]),
    .arr_rdata(arr_rdata), .pd7(pd[7]), .sect_prot(sect_prot), .rd_data(rd_data)
  );

  assign arr_addr   = prog_busy ? pgm_addr : rd_addr;
  assign pgm_stb    = prog_busy && tmr_done;
  assign pgm_wdata  = merge_prog(arr_rdata, pd);
  assign ers_stb    = ers_busy && tmr_done;
  assign busy       = prog_busy | ers_busy;
  assign ident_mode = (st == ST_IDENT);
  assign suspended  = (st == ST_ESUSP);
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_chk #(
  parameter int NSECT = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             busy,
  input logic             ident_mode,
  input logic             suspended,
  input logic             prog_busy,
  input logic             pgm_stb,
  input logic             pgm_refuse,
  input logic             ers_stb,
  input logic [NSECT-1:0] ers_mask,
  input logic [NSECT-1:0] sect_prot,
  input logic             res_ev,
  input logic [CNT_W-1:0] tmr_cnt
);
  // R3
  pgm_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_stb |=> (!busy && !ident_mode && !suspended));

  // R5
  pgm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && !pgm_stb) |=> prog_busy);

  // R9
  ident_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_mode && !(wr_en && wr_data == 8'hF0)) |=> ident_mode);

  // R10
  prot_pgm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_refuse |=> !busy);

  // R11
  ers_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ers_stb |-> (((ers_mask & sect_prot) == '0) && (ers_mask != '0)));

  // R12
  susp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !res_ev) |=> (suspended && $stable(tmr_cnt)));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.NSECT(NSECT), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
  .ident_mode(ident_mode), .suspended(suspended), .prog_busy(prog_busy),
  .pgm_stb(pgm_stb), .pgm_refuse(pgm_refuse), .ers_stb(ers_stb), .ers_mask(ers_mask),
  .sect_prot(sect_prot), .res_ev(res_ev), .tmr_cnt(tmr_cnt)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;
  localparam int CLK_P   = 10;
  localparam int ADDR_W  = 17;
  localparam int SECT_W  = 3;
  localparam int NSECT   = 1 << SECT_W;
  localparam int SSH     = ADDR_W - SECT_W;
  localparam int PGM_CYC = 6;
  localparam int ERS_CYC = 20;
  localparam logic [NSECT-1:0] PROT = 8'b0010_0100;

  // model modes
  localparam int M_READ = 0, M_U1 = 1, M_U2 = 2, M_PSET = 3, M_E0 = 4, M_E1 = 5,
                 M_E2 = 6, M_ID = 7, M_PB = 8, M_EB = 9, M_SU = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, arr_rdata, pgm_wdata;
  logic [ADDR_W-1:0] arr_addr, pgm_addr;
  logic pgm_stb, ers_stb, busy, ident_mode, suspended;
  logic [NSECT-1:0] ers_mask;
  logic [NSECT-1:0] sect_prot = PROT;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
    .sect_prot(sect_prot), .pgm_stb(pgm_stb), .pgm_addr(pgm_addr), .pgm_wdata(pgm_wdata),
    .ers_stb(ers_stb), .ers_mask(ers_mask), .busy(busy), .ident_mode(ident_mode),
    .suspended(suspended)
  );

  // environment array (driven by the DUT strobes) and expected array (model)
  logic [7:0] em[int];
  logic [7:0] mm[int];
  int em_ver = 0;

  function automatic logic [7:0] erd(input int a);
    return em.exists(a) ? em[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] mrd(input int a);
    return mm.exists(a) ? mm[a] : 8'hFF;
  endfunction

  always @(arr_addr or em_ver) arr_rdata = erd(int'(arr_addr));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // reference model state
  int ms = M_READ, rem = 0, mpa = 0;
  logic [7:0] mpd = '0;
  logic [NSECT-1:0] mmask = '0;
  bit model_on = 0;

  function automatic bit hit(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                             input int ea, input logic [7:0] ed);
    return (int'(a[10:0]) == ea) && (d == ed);
  endfunction

  function automatic logic [7:0] exp_rd();
    if (ms == M_ID) begin
      case (rd_addr[7:0])
        8'h00: return 8'h37;
        8'h01: return 8'hA1;
        8'h03: return 8'h7F;
        8'h02: return {7'b0, PROT[rd_addr >> SSH]};
        default: return 8'h00;
      endcase
    end
    if (ms == M_PB) return {~mpd[7], 7'b0};
    if (ms == M_EB) return 8'h00;
    return mrd(int'(rd_addr));
  endfunction

  always @(posedge clk) begin
    int keys[$];
    // environment array follows the DUT strobes
    if (pgm_stb) begin em[int'(pgm_addr)] = pgm_wdata; em_ver++; end
    if (ers_stb) begin
      keys.delete();
      foreach (em[k]) if (ers_mask[k >> SSH]) keys.push_back(k);
      foreach (keys[i]) em.delete(keys[i]);
      em_ver++;
    end
    // behavioural model
    if (!rst_n) begin
      ms = M_READ; rem = 0;
    end else begin
      case (ms)
        M_READ: if (wr_en && hit(wr_addr, wr_data, 'h555, 8'hAA)) ms = M_U1;
        M_U1:   if (wr_en) ms = hit(wr_addr, wr_data, 'h2AA, 8'h55) ? M_U2 : M_READ;
        M_U2:   if (wr_en) begin
                  if (hit(wr_addr, wr_data, 'h555, 8'hA0)) ms = M_PSET;
                  else if (hit(wr_addr, wr_data, 'h555, 8'h90)) ms = M_ID;
                  else if (hit(wr_addr, wr_data, 'h555, 8'h80)) ms = M_E0;
                  else ms = M_READ;
                end
        M_PSET: if (wr_en) begin
                  if (PROT[wr_addr >> SSH]) ms = M_READ;
                  else begin ms = M_PB; rem = PGM_CYC; mpa = int'(wr_addr); mpd = wr_data; end
                end
        M_E0:   if (wr_en) ms = hit(wr_addr, wr_data, 'h555, 8'hAA) ? M_E1 : M_READ;
        M_E1:   if (wr_en) ms = hit(wr_addr, wr_data, 'h2AA, 8'h55) ? M_E2 : M_READ;
        M_E2:   if (wr_en) begin
                  ms = M_READ;
                  mmask = '0;
                  if (wr_data == 8'h30) mmask[wr_addr >> SSH] = 1'b1;
                  else if (hit(wr_addr, wr_data, 'h555, 8'h10)) mmask = '1;
                  mmask = mmask & ~PROT;
                  if (mmask != '0) begin ms = M_EB; rem = ERS_CYC; end
                end
        M_ID:   if (wr_en && wr_data == 8'hF0) ms = M_READ;
        M_PB:   if (rem == 1) begin mm[mpa] = mrd(mpa) & mpd; ms = M_READ; end
                else rem--;
        M_EB:   if (rem == 1) begin
                  keys.delete();
                  foreach (mm[k]) if (mmask[k >> SSH]) keys.push_back(k);
                  foreach (keys[i]) mm.delete(keys[i]);
                  ms = M_READ;
                end else begin
                  rem--;
                  if (wr_en && wr_data == 8'hB0) ms = M_SU;
                end
        M_SU:   if (wr_en && wr_data == 8'h30) ms = M_EB;
        default: ms = M_READ;
      endcase
    end
    // compare every cycle, away from the edge
    #(CLK_P/4);
    if (model_on && rst_n) begin
      chk(busy == (ms == M_PB || ms == M_EB), "R3 R11 busy per cycle", busy, (ms == M_PB || ms == M_EB));
      chk(ident_mode == (ms == M_ID), "R7 R9 ident_mode per cycle", ident_mode, (ms == M_ID));
      chk(suspended == (ms == M_SU), "R12 suspended per cycle", suspended, (ms == M_SU));
      chk(rd_data == exp_rd(), "R1 R5 R7 rd_data per cycle", rd_data, exp_rd());
      chk(pgm_stb == (ms == M_PB && rem == 1), "R3 pgm_stb per cycle", pgm_stb, (ms == M_PB && rem == 1));
      chk(ers_stb == (ms == M_EB && rem == 1), "R11 ers_stb per cycle", ers_stb, (ms == M_EB && rem == 1));
      if (ms == M_EB && rem == 1) chk(ers_mask == mmask, "R11 ers_mask", ers_mask, mmask);
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(17'h00555, 8'hAA); wr(17'h002AA, 8'h55);
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_addr = a; #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic erase_seq(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    unlock(); wr(17'h00555, 8'h80); unlock(); wr(a, d);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1;
    @(negedge clk); #1;
    // R1: reset state
    chk(!busy && !ident_mode && !suspended, "R1 flags after reset", {busy, ident_mode, suspended}, 0);
    rd_chk(17'h01234, 8'hFF, "R1 array read after reset");

    // R3 / R5: program and busy window
    unlock(); wr(17'h00555, 8'hA0); wr(17'h01234, 8'h5A);
    chk(busy, "R3 busy after program write", busy, 1);
    #1 chk(rd_data == 8'h80, "R5 status byte while programming", rd_data, 8'h80);
    wr(17'h00000, 8'hF0);
    chk(busy, "R5 reset ignored while programming", busy, 1);
    repeat (PGM_CYC - 3) @(negedge clk);
    chk(busy, "R3 still busy in last cycle", busy, 1);
    @(negedge clk);
    chk(!busy, "R3 busy ends after PGM_CYC", busy, 0);
    rd_chk(17'h01234, 8'h5A, "R3 programmed byte");

    // R4: program only clears bits
    unlock(); wr(17'h00555, 8'hA0); wr(17'h01234, 8'hF3); wait_idle();
    rd_chk(17'h01234, 8'h52, "R4 AND of old and new");

    // R2: wrong address in unlock
    wr(17'h00555, 8'hAA); wr(17'h002AB, 8'h55); wr(17'h00555, 8'hA0); wr(17'h01234, 8'h00);
    chk(!busy, "R2 no program after bad unlock", busy, 0);
    rd_chk(17'h01234, 8'h52, "R2 array unchanged");
    // R2: wrong data in second cycle
    wr(17'h00555, 8'hAA); wr(17'h002AA, 8'h54); wr(17'h00555, 8'h90);
    chk(!ident_mode, "R2 no ident after bad data", ident_mode, 0);

    // R6: reset between unlock cycles, any address
    wr(17'h00555, 8'hAA); wr(17'h1FFFF, 8'hF0); wr(17'h002AA, 8'h55); wr(17'h00555, 8'hA0);
    wr(17'h01234, 8'h00);
    chk(!busy, "R6 reset aborted sequence", busy, 0);
    unlock(); wr(17'h0ABCD, 8'hF0); wr(17'h00555, 8'hA0); wr(17'h01234, 8'h00);
    rd_chk(17'h01234, 8'h52, "R6 array unchanged after aborted program");

    // R7 / R8 / R9: identification mode
    unlock(); wr(17'h00555, 8'h90);
    chk(ident_mode, "R7 ident mode entered", ident_mode, 1);
    rd_chk(17'h00000, 8'h37, "R7 manufacturer code");
    rd_chk(17'h1FF01, 8'hA1, "R7 device code");
    rd_chk(17'h00103, 8'h7F, "R7 continuation code");
    rd_chk(17'h00005, 8'h00, "R7 other address");
    rd_chk(17'h08002, 8'h01, "R8 protected sector 2");
    rd_chk(17'h14002, 8'h01, "R8 protected sector 5");
    rd_chk(17'h04002, 8'h00, "R8 unprotected sector 1");
    unlock(); wr(17'h00555, 8'hA0); wr(17'h01234, 8'h00);
    chk(ident_mode && !busy, "R9 writes ignored in ident", ident_mode, 1);
    rd_chk(17'h00000, 8'h37, "R9 codes still returned");
    wr(17'h12345, 8'hF0);
    chk(!ident_mode, "R9 reset leaves ident", ident_mode, 0);
    rd_chk(17'h01234, 8'h52, "R9 array read restored");

    // R10: program to protected sector
    unlock(); wr(17'h00555, 8'hA0); wr(17'h08010, 8'h00);
    chk(!busy, "R10 no busy on protected program", busy, 0);
    rd_chk(17'h08010, 8'hFF, "R10 protected byte unchanged");

    // R11: sector erase of sector 0
    unlock(); wr(17'h00555, 8'hA0); wr(17'h04000, 8'h11); wait_idle();
    erase_seq(17'h00000, 8'h30);
    chk(busy, "R11 erase busy", busy, 1);
    #1 chk(rd_data == 8'h00, "R11 status during erase", rd_data, 8'h00);
    wait_idle();
    rd_chk(17'h01234, 8'hFF, "R11 sector 0 erased");
    rd_chk(17'h04000, 8'h11, "R11 sector 1 kept");
    erase_seq(17'h14000, 8'h30);
    chk(!busy, "R11 protected sector erase ends at once", busy, 0);

    // R12: suspend and resume
    unlock(); wr(17'h00555, 8'hA0); wr(17'h01000, 8'h33); wait_idle();
    erase_seq(17'h00000, 8'h30);
    repeat (4) @(negedge clk);
    wr(17'h00000, 8'hB0);
    chk(suspended && !busy, "R12 suspended", {suspended, busy}, 2'b10);
    rd_chk(17'h01000, 8'h33, "R12 array readable while suspended");
    wr(17'h00000, 8'hF0); unlock();
    repeat (30) @(negedge clk);
    chk(suspended, "R12 still suspended", suspended, 1);
    wr(17'h00000, 8'h30);
    chk(busy, "R12 resumed", busy, 1);
    wait_idle();
    rd_chk(17'h01000, 8'hFF, "R12 erase finished after resume");

    // R11: whole-array erase skips protected sectors
    erase_seq(17'h00555, 8'h10);
    wait_idle();
    rd_chk(17'h04000, 8'hFF, "R11 chip erase cleared sector 1");

    repeat (3) @(negedge clk);
    report();
  end
endmodule